// File: doc/BRIEF.md
# Peripheral-side DMA request/acknowledge handshake

This block is the device end of a classic third-party DMA handshake. It moves one buffer between a local FIFO and the system data bus. Software loads a unit count and a mode, then pulses a start input. The block raises a request line and waits for the bus master's active-low acknowledge. It then moves one byte for each completed data strobe: it pops the FIFO head onto the bus when the device is read, or pushes the bus byte into the FIFO when the device is written. When the last unit completes, it reports completion with a one-clock pulse.

Three mode bits are latched at start. The first picks the direction. The second picks single-cycle or burst pacing. In single-cycle pacing the request is dropped after every unit. In burst pacing it is held until the final unit. The third bit makes the acknowledge line itself the data strobe. In that case the separate read and write strobes are disregarded, which suits hosts that share one address space for memory and I/O. All handshake inputs are asynchronous. They are brought into the clock domain through a multi-flop synchronizer, and a unit counts on the trailing edge of its strobe.

Top module: `dma_periph_if`

## Requirements
- R1: While reset is held, and in the first cycle after it, `dreq`, `done`, `bus_oe`, `fifo_rd_en` and `fifo_wr_en` are all 0.
- R2: A start with count N>0 completes exactly N units. `done` is then high for exactly one clock, and `dreq` is 0 from that point on. A start with count 0 gives a single `done` pulse and never raises `dreq`.
- R3: With the ack-strobe mode bit clear and the device being read, `bus_oe` is 1 and `bus_dout` equals the FIFO head only while `dack_n` and `rd_n` are both low. Acknowledge alone leaves `bus_oe` at 0.
- R4: With the ack-strobe mode bit set, a low `dack_n` alone is the strobe. In read direction it enables the bus driver without `rd_n`. Toggling `rd_n` or `wr_n` while `dack_n` is high moves no data and enables nothing.
- R5: Each strobe completes one unit on its trailing (rising, active-low) edge, seen after synchronization. Each unit gives exactly one FIFO pop (read) or one FIFO push (write).
- R6: In write direction, the byte present on `bus_din` during the strobe is pushed into the FIFO at the trailing edge, in transfer order.
- R7: `bus_oe` is never 1 in write direction (mode bit `cfg_to_device`=1), and `fifo_wr_en` is never 1 in read direction.
- R8: In single-cycle pacing, `dreq` goes low after each unit. It rises again no earlier than one clock after the synchronized acknowledge has been seen high (deasserted).
- R9: In burst pacing, `dreq` stays high across units while the FIFO stays ready. It falls only after the final unit.
- R10: `dreq` is not asserted while the FIFO is empty in read direction or full in write direction.
- R11: A 64-unit packet, the default count, completes with every byte in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_start | input | 1 | One-clock pulse that latches mode and count and begins a transfer (ignored while busy) |
| cfg_count | input | CNT_W | Number of units to move |
| cfg_ack_strobe | input | 1 | 1: acknowledge is the data strobe, read/write strobes disregarded |
| cfg_burst | input | 1 | 1: burst pacing, 0: single-cycle pacing |
| cfg_to_device | input | 1 | 1: bus writes into the FIFO, 0: FIFO is read onto the bus |
| dreq | output | 1 | Request to the DMA master, active high |
| dack_n | input | 1 | Acknowledge from the DMA master, active low, asynchronous |
| rd_n | input | 1 | Read strobe, active low, asynchronous |
| wr_n | input | 1 | Write strobe, active low, asynchronous |
| bus_din | input | DATA_W | Bus data toward the device |
| bus_dout | output | DATA_W | Bus data from the device (FIFO head) |
| bus_oe | output | 1 | Enable for the bus driver |
| fifo_rd_data | input | DATA_W | FIFO head, first-word fall-through |
| fifo_empty | input | 1 | FIFO has no data |
| fifo_rd_en | output | 1 | Pop the FIFO head |
| fifo_wr_data | output | DATA_W | Byte to push |
| fifo_full | input | 1 | FIFO has no room |
| fifo_wr_en | output | 1 | Push `fifo_wr_data` |
| done | output | 1 | One-clock pulse when the transfer finishes |

## Verification
Several properties are watched on every clock. The completion pulse is one cycle wide, and no request is raised in the cycle it fires. The request falls after a single-cycle unit, and it never re-arms while the acknowledge was still seen low. A burst keeps its request, and every request follows a ready FIFO. The bus driver stays off in write direction, and read/write strobe activity alone never completes a unit in ack-strobe mode. Other behaviour can only be shown by the bench's scenarios, which sweep both directions, both pacings and both strobe sources. These are the byte-exact order of FIFO traffic, the unit totals for counts 0, small N and 64, the per-strobe bus data, and the stall while the FIFO is not ready.

// File: rtl/dma_periph_pkg.sv
package dma_periph_pkg;

   // Mode bits latched when a transfer starts.
   typedef struct packed {
      logic strobe_on_ack;  // acknowledge doubles as data strobe
      logic burst;          // hold request across units
      logic to_device;      // bus -> FIFO when set
   } xfer_mode_t;

   localparam int unsigned CTL_LINES = 3;  // ack, rd, wr

endpackage

// File: rtl/dma_sync.sv
module dma_sync #(
   parameter int unsigned WIDTH  = 1,
   parameter int unsigned STAGES = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("dma_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("dma_sync: WIDTH must be at least 1");
   end

   logic [WIDTH-1:0] stage_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < int'(STAGES); i++) stage_q[i] <= RST_VAL;
      end else begin
         stage_q[0] <= d;
         for (int i = 1; i < int'(STAGES); i++) stage_q[i] <= stage_q[i-1];
      end
   end

   assign q = stage_q[STAGES-1];

endmodule

// File: rtl/dma_xfer_path.sv
module dma_xfer_path
   import dma_periph_pkg::*;
#(
   parameter int unsigned DATA_W       = 8,
   parameter bit          OE_FROM_PINS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              active,
   input  xfer_mode_t        mode,
   input  logic              ack_s,
   input  logic              rd_s,
   input  logic              wr_s,
   input  logic              ack_pin,
   input  logic              rd_pin,
   input  logic [DATA_W-1:0] bus_din_d,
   input  logic [DATA_W-1:0] fifo_rd_data,
   output logic              unit_done,
   output logic              bus_oe,
   output logic [DATA_W-1:0] bus_dout,
   output logic              fifo_rd_en,
   output logic              fifo_wr_en,
   output logic [DATA_W-1:0] fifo_wr_data
);

   logic              strobe_now;
   logic              strobe_q;
   logic [DATA_W-1:0] cap_q;

   // Qualified strobe in the synchronized domain.
   always_comb begin
      if (mode.strobe_on_ack) strobe_now = active && ack_s;
      else if (mode.to_device) strobe_now = active && ack_s && wr_s;
      else                     strobe_now = active && ack_s && rd_s;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         strobe_q <= 1'b0;
         cap_q    <= '0;
      end else begin
         strobe_q <= strobe_now;
         if (strobe_now) cap_q <= bus_din_d;
      end
   end

   // Trailing edge of the strobe completes one unit.
   assign unit_done    = active && strobe_q && !strobe_now;
   assign fifo_rd_en   = unit_done && !mode.to_device;
   assign fifo_wr_en   = unit_done &&  mode.to_device;
   assign fifo_wr_data = cap_q;
   assign bus_dout     = fifo_rd_data;

   // Driver enable: straight from the pins (no latency) or from the
   // synchronized copies (glitch-free, lags by the synchronizer depth).
   if (OE_FROM_PINS) begin : g_oe_pins
      assign bus_oe = active && !mode.to_device && ack_pin &&
                      (mode.strobe_on_ack || rd_pin);
   end else begin : g_oe_sync
      assign bus_oe = active && !mode.to_device && ack_s &&
                      (mode.strobe_on_ack || rd_s);
   end

   // R4: read/write strobe motion alone never completes a unit
   p_ack_only_ignores_rw_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (active && mode.strobe_on_ack && $stable(ack_s)) |-> !unit_done);

   // R7: no push while the FIFO is the source
   p_no_push_on_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_wr_en |-> mode.to_device);

endmodule

// File: rtl/dma_req_ctrl.sv
module dma_req_ctrl
   import dma_periph_pkg::*;
#(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  xfer_mode_t       cfg_mode,
   input  logic [CNT_W-1:0] cfg_count,
   input  logic             unit_done,
   input  logic             ack_s,
   input  logic             fifo_empty,
   input  logic             fifo_full,
   output xfer_mode_t       mode,
   output logic             active,
   output logic             dreq,
   output logic             done
);

   xfer_mode_t       mode_q;
   logic [CNT_W-1:0] remain_q;
   logic             active_q, done_q, hold_q, dreq_q;
   logic             accept, last_unit, ready, dreq_d, hold_d;

   assign accept    = start && !active_q;
   assign last_unit = unit_done && active_q && (remain_q == CNT_W'(1));
   assign ready     = mode_q.to_device ? !fifo_full : !fifo_empty;

   always_comb begin
      dreq_d = active_q && ready && !hold_q && !last_unit &&
               !(unit_done && !mode_q.burst);
      if (accept)                                   hold_d = 1'b0;
      else if (unit_done && active_q && !mode_q.burst) hold_d = 1'b1;
      else if (!ack_s)                              hold_d = 1'b0;
      else                                          hold_d = hold_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q   <= '0;
         remain_q <= '0;
         active_q <= 1'b0;
         done_q   <= 1'b0;
         hold_q   <= 1'b0;
         dreq_q   <= 1'b0;
      end else begin
         done_q <= 1'b0;
         dreq_q <= dreq_d;
         hold_q <= hold_d;
         if (accept) begin
            mode_q   <= cfg_mode;
            remain_q <= cfg_count;
            active_q <= (cfg_count != '0);
            done_q   <= (cfg_count == '0);
         end else if (unit_done && active_q) begin
            remain_q <= remain_q - CNT_W'(1);
            if (last_unit) begin
               active_q <= 1'b0;
               done_q   <= 1'b1;
            end
         end
      end
   end

   assign mode   = mode_q;
   assign active = active_q;
   assign dreq   = dreq_q;
   assign done   = done_q;

   // R2: completion is a single-cycle pulse
   p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q);
   // R2: no request once finished
   p_quiet_at_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |-> !dreq_q);
   // R8: single-cycle pacing drops the request after a unit
   p_single_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (unit_done && active_q && !mode_q.burst) |=> !dreq_q);
   // R8: re-arm only after acknowledge seen released
   p_rearm_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_q.burst && $rose(dreq_q)) |-> !$past(ack_s));
   // R9: burst keeps the request between units
   p_burst_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (dreq_q && mode_q.burst && unit_done && !last_unit && ready) |=> dreq_q);
   // R10: request only follows a ready FIFO
   p_ready_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
      dreq_q |-> $past(ready));

endmodule

// File: rtl/dma_periph_if.sv
module dma_periph_if
   import dma_periph_pkg::*;
#(
   parameter int unsigned DATA_W       = 8,
   parameter int unsigned CNT_W        = 8,
   parameter int unsigned SYNC_STAGES  = 2,
   parameter int unsigned PACKET_UNITS = 64,
   parameter bit          OE_FROM_PINS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_start,
   input  logic [CNT_W-1:0]  cfg_count,
   input  logic              cfg_ack_strobe,
   input  logic              cfg_burst,
   input  logic              cfg_to_device,
   output logic              dreq,
   input  logic              dack_n,
   input  logic              rd_n,
   input  logic              wr_n,
   input  logic [DATA_W-1:0] bus_din,
   output logic [DATA_W-1:0] bus_dout,
   output logic              bus_oe,
   input  logic [DATA_W-1:0] fifo_rd_data,
   input  logic              fifo_empty,
   output logic              fifo_rd_en,
   output logic [DATA_W-1:0] fifo_wr_data,
   input  logic              fifo_full,
   output logic              fifo_wr_en,
   output logic              done
);

   localparam longint unsigned COUNT_MAX = (64'd1 << CNT_W) - 64'd1;

   if (PACKET_UNITS > COUNT_MAX) begin : g_bad_cnt
      $error("dma_periph_if: CNT_W too narrow for PACKET_UNITS");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("dma_periph_if: DATA_W must be positive");
   end

   logic [CTL_LINES-1:0] ctl_s_n;
   logic [DATA_W-1:0]    din_d;
   logic                 ack_s, rd_s, wr_s;
   logic                 unit_done, active;
   xfer_mode_t           cfg_mode, mode;

   assign cfg_mode = '{strobe_on_ack: cfg_ack_strobe, burst: cfg_burst,
                       to_device: cfg_to_device};

   dma_sync #(.WIDTH(CTL_LINES), .STAGES(SYNC_STAGES),
              .RST_VAL({CTL_LINES{1'b1}})) i_ctl_sync (
      .clk(clk), .rst_n(rst_n), .d({dack_n, rd_n, wr_n}), .q(ctl_s_n));

   // Data delayed by the same depth so it lines up with the strobe.
   dma_sync #(.WIDTH(DATA_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) i_data_dly (
      .clk(clk), .rst_n(rst_n), .d(bus_din), .q(din_d));

   assign ack_s = !ctl_s_n[2];
   assign rd_s  = !ctl_s_n[1];
   assign wr_s  = !ctl_s_n[0];

   dma_req_ctrl #(.CNT_W(CNT_W)) i_req (
      .clk(clk), .rst_n(rst_n), .start(cfg_start), .cfg_mode(cfg_mode),
      .cfg_count(cfg_count), .unit_done(unit_done), .ack_s(ack_s),
      .fifo_empty(fifo_empty), .fifo_full(fifo_full), .mode(mode),
      .active(active), .dreq(dreq), .done(done));

   dma_xfer_path #(.DATA_W(DATA_W), .OE_FROM_PINS(OE_FROM_PINS)) i_path (
      .clk(clk), .rst_n(rst_n), .active(active), .mode(mode),
      .ack_s(ack_s), .rd_s(rd_s), .wr_s(wr_s),
      .ack_pin(!dack_n), .rd_pin(!rd_n), .bus_din_d(din_d),
      .fifo_rd_data(fifo_rd_data), .unit_done(unit_done), .bus_oe(bus_oe),
      .bus_dout(bus_dout), .fifo_rd_en(fifo_rd_en), .fifo_wr_en(fifo_wr_en),
      .fifo_wr_data(fifo_wr_data));

   // R7: bus driver idle whenever the latched direction is toward the device
   p_no_oe_to_device_r7: assert property (@(posedge clk) disable iff (!rst_n)
      bus_oe |-> !mode.to_device);
   // R5: at most one FIFO side moves per cycle
   p_one_side_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !(fifo_rd_en && fifo_wr_en));

endmodule

// File: tb/test_dma_periph_if.sv
module test_dma_periph_if;

   localparam int DW = 8;
   localparam int CW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_start = 1'b0;
   logic [CW-1:0] cfg_count = '0;
   logic          cfg_ack_strobe = 1'b0, cfg_burst = 1'b0, cfg_to_device = 1'b0;
   logic          dreq;
   logic          dack_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
   logic [DW-1:0] bus_din = '0;
   logic [DW-1:0] bus_dout;
   logic          bus_oe;
   logic [DW-1:0] fifo_rd_data;
   logic          fifo_empty;
   logic          fifo_rd_en;
   logic [DW-1:0] fifo_wr_data;
   logic          fifo_full;
   logic          fifo_wr_en;
   logic          done;

   always #4 clk = ~clk;  // 125 MHz

   dma_periph_if i_dma_periph_if (
      .clk(clk), .rst_n(rst_n), .cfg_start(cfg_start), .cfg_count(cfg_count),
      .cfg_ack_strobe(cfg_ack_strobe), .cfg_burst(cfg_burst),
      .cfg_to_device(cfg_to_device), .dreq(dreq), .dack_n(dack_n),
      .rd_n(rd_n), .wr_n(wr_n), .bus_din(bus_din), .bus_dout(bus_dout),
      .bus_oe(bus_oe), .fifo_rd_data(fifo_rd_data), .fifo_empty(fifo_empty),
      .fifo_rd_en(fifo_rd_en), .fifo_wr_data(fifo_wr_data),
      .fifo_full(fifo_full), .fifo_wr_en(fifo_wr_en), .done(done));

   // FIFO model
   logic [DW-1:0] src_mem [256];
   logic [DW-1:0] dst_mem [256];
   int rd_ptr = 0, rd_avail = 0, wr_cnt = 0;
   logic full_force = 1'b0;
   assign fifo_rd_data = src_mem[rd_ptr[7:0]];
   assign fifo_empty   = (rd_ptr >= rd_avail);
   assign fifo_full    = full_force;

   always @(posedge clk) begin
      if (fifo_rd_en) rd_ptr <= rd_ptr + 1;
      if (fifo_wr_en) begin
         dst_mem[wr_cnt[7:0]] <= fifo_wr_data;
         wr_cnt <= wr_cnt + 1;
      end
   end

   // Monitors
   int done_cnt = 0, done_wide = 0, oe_bad = 0;
   logic done_prev = 1'b0;
   logic cur_dir = 1'b0;
   always @(negedge clk) begin
      if (done) done_cnt++;
      if (done && done_prev) done_wide++;
      done_prev = done;
      if (bus_oe && cur_dir) oe_bad++;
   end

   int total = 0, bad = 0;
   bit finished = 1'b0;

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic logic [DW-1:0] pat(input int r, input int i);
      return DW'(r * 37 + i * 13 + 5);
   endfunction

   task automatic wait_req(input string req);
      for (int k = 0; k < 300 && !dreq; k++) @(negedge clk);
      check(dreq == 1'b1, req, "request never raised", int'(dreq), 1);
   endtask

   task automatic start_run(input bit dir, input bit burst, input bit donly,
                            input int n, input int r);
      @(negedge clk);
      cur_dir = dir;
      rd_ptr = 0; wr_cnt = 0; done_cnt = 0; done_wide = 0;
      for (int i = 0; i < 256; i++) src_mem[i] = pat(r, i);
      rd_avail = dir ? 0 : n;
      cfg_to_device = dir; cfg_burst = burst; cfg_ack_strobe = donly;
      cfg_count = CW'(n);
      cfg_start = 1'b1;
      @(negedge clk);
      cfg_start = 1'b0;
   endtask

   task automatic do_unit(input bit dir, input bit burst, input bit donly,
                          input int idx, input bit last, input int r);
      wait_req(burst ? "R9" : "R8");
      bus_din = pat(r, idx);
      if (!donly) begin
         dack_n = 1'b0;
         repeat (4) @(negedge clk);
         if (!dir) check(bus_oe == 1'b0, "R3", "oe with ack only", int'(bus_oe), 0);
         if (dir) wr_n = 1'b0; else rd_n = 1'b0;
      end else begin
         dack_n = 1'b0;
      end
      repeat (5) @(negedge clk);
      if (!dir) begin
         check(bus_oe == 1'b1, donly ? "R4" : "R3", "oe during strobe", int'(bus_oe), 1);
         check(bus_dout == pat(r, idx), "R3", "bus byte", int'(bus_dout), int'(pat(r, idx)));
      end else begin
         check(bus_oe == 1'b0, "R7", "oe in write direction", int'(bus_oe), 0);
      end
      if (donly) dack_n = 1'b1; else begin rd_n = 1'b1; wr_n = 1'b1; end
      if (donly && !burst && !last) begin
         repeat (3) @(negedge clk);
         check(dreq == 1'b0, "R8", "rearm gap (ack strobe)", int'(dreq), 0);
         repeat (2) @(negedge clk);
      end else begin
         repeat (5) @(negedge clk);
      end
      check((dir ? wr_cnt : rd_ptr) == idx + 1, "R5", "units moved", dir ? wr_cnt : rd_ptr, idx + 1);
      if (last) begin
         check(dreq == 1'b0, "R2", "request after last", int'(dreq), 0);
         dack_n = 1'b1;
      end else if (burst) begin
         check(dreq == 1'b1, "R9", "burst request held", int'(dreq), 1);
      end else if (!donly) begin
         check(dreq == 1'b0, "R8", "single drop", int'(dreq), 0);
         dack_n = 1'b1;
         repeat (3) @(negedge clk);
         check(dreq == 1'b0, "R8", "rearm gap", int'(dreq), 0);
      end
   endtask

   task automatic finish_run(input bit dir, input int n, input int r, input string req);
      repeat (4) @(negedge clk);
      check(done_cnt == 1, req, "done pulses", done_cnt, 1);
      check(done_wide == 0, "R2", "done wider than one clock", done_wide, 0);
      check(oe_bad == 0, "R7", "oe cycles in write direction", oe_bad, 0);
      if (dir) begin
         check(rd_ptr == 0, "R7", "pops in write direction", rd_ptr, 0);
         check(wr_cnt == n, req, "push total", wr_cnt, n);
         for (int i = 0; i < n; i++)
            check(dst_mem[i] == pat(r, i), "R6", "pushed byte", int'(dst_mem[i]), int'(pat(r, i)));
      end else begin
         check(wr_cnt == 0, "R7", "pushes in read direction", wr_cnt, 0);
         check(rd_ptr == n, req, "pop total", rd_ptr, n);
      end
   endtask

   task automatic run(input bit dir, input bit burst, input bit donly,
                      input int n, input int r, input string req);
      start_run(dir, burst, donly, n, r);
      if (donly) begin
         // R4: strobes without acknowledge must do nothing
         for (int k = 0; k < 3; k++) begin
            bus_din = 8'hA5;
            rd_n = 1'b0; wr_n = 1'b0;
            repeat (4) @(negedge clk);
            check(bus_oe == 1'b0, "R4", "oe from rd_n alone", int'(bus_oe), 0);
            rd_n = 1'b1; wr_n = 1'b1;
            repeat (4) @(negedge clk);
         end
         check((dir ? wr_cnt : rd_ptr) == 0, "R4", "units from rd/wr alone", dir ? wr_cnt : rd_ptr, 0);
      end
      for (int i = 0; i < n; i++) do_unit(dir, burst, donly, i, i == n - 1, r);
      finish_run(dir, n, r, req);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check(dreq == 0 && done == 0 && bus_oe == 0 && fifo_rd_en == 0 && fifo_wr_en == 0,
            "R1", "outputs in reset", int'({dreq, done, bus_oe, fifo_rd_en, fifo_wr_en}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(dreq == 0 && done == 0 && bus_oe == 0, "R1", "outputs after reset",
            int'({dreq, done, bus_oe}), 0);

      // Sweep direction, pacing and strobe source
      for (int c = 0; c < 8; c++)
         run(c[0], c[1], c[2], 3 + c[0], c, "R2");

      // Zero count
      start_run(1'b0, 1'b0, 1'b0, 0, 20);
      repeat (10) @(negedge clk);
      check(dreq == 1'b0, "R2", "request on zero count", int'(dreq), 0);
      check(done_cnt == 1, "R2", "done pulses on zero count", done_cnt, 1);

      // FIFO gating, read side
      start_run(1'b0, 1'b0, 1'b0, 2, 21);
      rd_avail = 0;
      repeat (10) @(negedge clk);
      check(dreq == 1'b0, "R10", "request with empty FIFO", int'(dreq), 0);
      rd_avail = 2;
      do_unit(1'b0, 1'b0, 1'b0, 0, 1'b0, 21);
      do_unit(1'b0, 1'b0, 1'b0, 1, 1'b1, 21);
      finish_run(1'b0, 2, 21, "R10");

      // FIFO gating, write side
      full_force = 1'b1;
      start_run(1'b1, 1'b1, 1'b0, 2, 22);
      repeat (10) @(negedge clk);
      check(dreq == 1'b0, "R10", "request with full FIFO", int'(dreq), 0);
      full_force = 1'b0;
      do_unit(1'b1, 1'b1, 1'b0, 0, 1'b0, 22);
      do_unit(1'b1, 1'b1, 1'b0, 1, 1'b1, 22);
      finish_run(1'b1, 2, 22, "R10");

      // Full bulk packet
      run(1'b1, 1'b1, 1'b1, 64, 30, "R11");
      run(1'b0, 1'b0, 1'b0, 64, 31, "R11");

      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL R2 watchdog actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule